// File: doc/BRIEF.md
# Packed 2-bit pixel frame buffer

This block is a frame store for 2-bit pixels. Instead of giving each pixel a power-of-two slot, it lays the pixels end to end in one continuous bit stream and stores that stream in 9-bit memory words. Every bit of every word therefore holds pixel data. As a result, some pixels start in the top bit of one word and end in bit 0 of the next word.

A capture side writes one pixel per cycle by giving a coordinate and a 2-bit value. A display raster reads one pixel per cycle by giving a coordinate, and it gets the pixel back two cycles later. The memory is split into an even-word bank and an odd-word bank. Because of this split, both halves of a straddling pixel are reached in a single cycle. Writes use per-bit enables, so they never need a read-modify-write.

The frame size is set by parameters. The default is 64 by 32 pixels. The address arithmetic is built to handle a frame of up to 512 by 256 pixels.

Top module: `packed_pix_fb`

## Requirements
- R1: While reset is held, `rd_pix` reads 00.
- R2: Pixel (x,y) has index n = y*FB_W + x and occupies bits 2n and 2n+1 of a continuous stream of 9-bit words. Its word is floor(2n/9) and its low bit sits at bit 2n mod 9 of that word. Any written pixel reads back its value, including the last pixel of the frame and pixels held in odd-numbered words.
- R3: The word/offset divider is exact for every bit position 2n with n from 0 to 131071.
- R4: A write changes only the 2 bits of the addressed pixel. This holds when the offset is 8, where the low bit lands in bit 8 of word k and the high bit lands in bit 0 of word k+1. The neighbouring pixels keep their values.
- R5: If a write and a read address the same pixel in the same cycle, the read returns the newly written value.
- R6: Read data for a coordinate appears on `rd_pix` exactly 2 clock edges after the coordinate is sampled, whatever the offset. Back-to-back reads stream one pixel per cycle.
- R7: A write with x >= FB_W or y >= FB_H changes no stored pixel. A read with such a coordinate returns 00.
- R8: All four codes 00, 01, 10 and 11 are stored and returned unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_x | input | clog2(FB_W)+1 | Write column |
| wr_y | input | clog2(FB_H)+1 | Write line |
| wr_pix | input | 2 | Pixel code to store |
| rd_x | input | clog2(FB_W)+1 | Read column |
| rd_y | input | clog2(FB_H)+1 | Read line |
| rd_pix | output | 2 | Pixel code, two cycles after the read coordinate |

## Verification
The hardest case to reach from the ports is a pixel at offset 8 whose two bits sit in different banks. That case is hardest when it is combined with a write to the same pixel in the same cycle, or with writes to its neighbours on both sides. The stimulus targets pixel indices that are congruent to 4 mod 9, which always straddle a word boundary. It surrounds such a pixel with distinct codes, overwrites it, and reads it in the same cycle as a write. The full 131072-index range of the divider cannot be reached through a frame of default size. The bench therefore also drives a divider built at full width and sweeps every index.

// File: rtl/fb_pkg.sv
// Package: shared widths for the packed pixel store.
// Assumes pixels are 2 bits and memory words are 9 bits.
package fb_pkg;
    localparam int WORD_BITS = 9;
    localparam int PIX_BITS  = 2;
    localparam int PAIR_BITS = 2 * WORD_BITS;
    typedef logic [WORD_BITS-1:0] word_t;
    typedef logic [PAIR_BITS-1:0] pair_t;
    typedef logic [PIX_BITS-1:0]  pix_t;
endpackage

// File: rtl/pix_div9.sv
// pix_div9: splits a bit position into a 9-bit word index and a bit offset.
// The quotient comes from a multiply by a scaled reciprocal. One correction
// step then fixes an estimate that can be low by at most one.
// Assumes BW <= 30 so that the product fits the constant arithmetic.
module pix_div9 #(
    parameter int BW = 18
) (
    input  logic [BW-1:0] b,
    output logic [BW-1:0] q,
    output logic [3:0]    r
);
    localparam int SH = BW + 3;
    localparam int PW = BW + SH;
    localparam longint unsigned RECIP = (64'd1 << SH) / 64'd9;

    logic [PW-1:0] prod;
    logic [BW-1:0] q_est;
    logic [BW-1:0] r_est;

    assign prod  = PW'(b) * PW'(RECIP);
    assign q_est = prod[PW-1:SH];
    assign r_est = b - q_est * BW'(9);

    // Correct an estimate that came out one short.
    always_comb begin
        if (r_est >= BW'(9)) begin
            q = q_est + 1'b1;
            r = 4'(r_est - BW'(9));
        end else begin
            q = q_est;
            r = 4'(r_est);
        end
    end

    // Check that the quotient and remainder rebuild the input.
    always_comb begin
        if (!$isunknown(b)) begin
            assert_div_range_R3: assert (r < 4'd9)
                else $error("divider remainder out of range");
            assert_div_exact_R3: assert ((q * BW'(9)) + BW'(r) == b)
                else $error("divider result inexact");
        end
    end
endmodule

// File: rtl/pix_locate.sv
// pix_locate: maps a coordinate to the index of its first word and its bit offset.
// Assumes XW/YW are wide enough to express out-of-range coordinates.
// An out-of-range coordinate gives ok=0 and is forced to index 0.
module pix_locate #(
    parameter int FB_W = 64,
    parameter int FB_H = 32,
    parameter int XW   = 7,
    parameter int YW   = 6,
    parameter int BW   = 13
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    output logic          ok,
    output logic [BW-1:0] k,
    output logic [3:0]    off
);
    logic [BW-1:0] idx;
    logic [BW-1:0] bitpos;

    assign ok     = (x < XW'(FB_W)) && (y < YW'(FB_H));
    assign idx    = ok ? (BW'(y) * BW'(FB_W) + BW'(x)) : '0;
    assign bitpos = {idx[BW-2:0], 1'b0};

    pix_div9 #(.BW(BW)) u_div (
        .b (bitpos),
        .q (k),
        .r (off)
    );
endmodule

// File: rtl/pix_bank.sv
// pix_bank: one bank of 9-bit words with per-bit write enables.
// The read is registered. When the read and the write address match,
// the read takes the new bits (write-first).
// Assumes the contents are not reset; only the read register is.
module pix_bank #(
    parameter int DEPTH = 229,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fb_pkg::word_t    be,
    input  logic [AW-1:0]    waddr,
    input  fb_pkg::word_t    wdata,
    input  logic [AW-1:0]    raddr,
    output fb_pkg::word_t    rdata
);
    fb_pkg::word_t mem [DEPTH];

    // Update only the enabled bits of the addressed word.
    always_ff @(posedge clk) begin
        for (int i = 0; i < fb_pkg::WORD_BITS; i++) begin
            if (be[i]) mem[waddr][i] <= wdata[i];
        end
    end

    // Registered read; merge bits written this cycle on an address match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (waddr == raddr)
            rdata <= (mem[raddr] & ~be) | (wdata & be);
        else
            rdata <= mem[raddr];
    end

    assert_wr_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|be) && (waddr == raddr)) |=> ((rdata & $past(be)) == ($past(wdata) & $past(be))))
        else $error("bank read missed same-cycle write");
endmodule

// File: rtl/packed_pix_fb.sv
// packed_pix_fb: a frame of 2-bit pixels packed end to end in 9-bit words,
// held in an even bank and an odd bank.
// Write: the coordinate is registered with its split masks, then the banks
// are written. Read: the coordinate is registered, then the banks are read,
// and the pixel is extracted, so data appears 2 edges after sampling.
// Assumes a single clock and a synchronous active-low reset.
module packed_pix_fb #(
    parameter int FB_W = 64,
    parameter int FB_H = 32,
    localparam int XW  = $clog2(FB_W) + 1,
    localparam int YW  = $clog2(FB_H) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [XW-1:0] wr_x,
    input  logic [YW-1:0] wr_y,
    input  logic [1:0]    wr_pix,
    input  logic [XW-1:0] rd_x,
    input  logic [YW-1:0] rd_y,
    output logic [1:0]    rd_pix
);
    import fb_pkg::*;

    localparam int NPIX   = FB_W * FB_H;
    localparam int NW     = $clog2(NPIX);
    localparam int BW     = NW + 1;
    localparam int WORDS  = (2 * NPIX + WORD_BITS - 1) / WORD_BITS;
    localparam int BANK_D = WORDS / 2 + 1;
    localparam int AW     = $clog2(BANK_D);

    // ---------------- write side ----------------
    logic          w_ok;
    logic [BW-1:0] w_k, w_k_inc;
    logic [3:0]    w_off;
    pair_t         w_win_d, w_win_m;
    word_t         w_be_e, w_be_o, w_d_e, w_d_o;

    pix_locate #(.FB_W(FB_W), .FB_H(FB_H), .XW(XW), .YW(YW), .BW(BW)) u_wloc (
        .x(wr_x), .y(wr_y), .ok(w_ok), .k(w_k), .off(w_off)
    );

    assign w_k_inc = w_k + 1'b1;
    assign w_win_d = PAIR_BITS'(wr_pix) << w_off;
    assign w_win_m = (wr_en && w_ok) ? (PAIR_BITS'(2'b11) << w_off) : '0;

    // Route the lower and upper word halves to banks by word parity.
    always_comb begin
        if (!w_k[0]) begin
            w_d_e  = w_win_d[WORD_BITS-1:0];  w_be_e = w_win_m[WORD_BITS-1:0];
            w_d_o  = w_win_d[PAIR_BITS-1:WORD_BITS]; w_be_o = w_win_m[PAIR_BITS-1:WORD_BITS];
        end else begin
            w_d_o  = w_win_d[WORD_BITS-1:0];  w_be_o = w_win_m[WORD_BITS-1:0];
            w_d_e  = w_win_d[PAIR_BITS-1:WORD_BITS]; w_be_e = w_win_m[PAIR_BITS-1:WORD_BITS];
        end
    end

    logic          w_ok_q;
    logic [AW-1:0] w_ae_q, w_ao_q;
    word_t         w_be_e_q, w_be_o_q, w_d_e_q, w_d_o_q;

    // Register the write request ahead of the banks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_ok_q <= 1'b0; w_ae_q <= '0; w_ao_q <= '0;
            w_be_e_q <= '0; w_be_o_q <= '0; w_d_e_q <= '0; w_d_o_q <= '0;
        end else begin
            w_ok_q   <= wr_en && w_ok;
            w_ae_q   <= AW'(w_k_inc >> 1);
            w_ao_q   <= AW'(w_k >> 1);
            w_be_e_q <= w_be_e;
            w_be_o_q <= w_be_o;
            w_d_e_q  <= w_d_e;
            w_d_o_q  <= w_d_o;
        end
    end

    // ---------------- read side ----------------
    logic          r_ok;
    logic [BW-1:0] r_k, r_k_inc;
    logic [3:0]    r_off;

    pix_locate #(.FB_W(FB_W), .FB_H(FB_H), .XW(XW), .YW(YW), .BW(BW)) u_rloc (
        .x(rd_x), .y(rd_y), .ok(r_ok), .k(r_k), .off(r_off)
    );
    assign r_k_inc = r_k + 1'b1;

    logic          r_ok_q1, r_par_q1, r_ok_q2, r_par_q2;
    logic [3:0]    r_off_q1, r_off_q2;
    logic [AW-1:0] r_ae_q1, r_ao_q1;

    // Two-stage alignment of the read control with bank data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_ok_q1 <= 1'b0; r_par_q1 <= 1'b0; r_off_q1 <= '0;
            r_ae_q1 <= '0;   r_ao_q1  <= '0;
            r_ok_q2 <= 1'b0; r_par_q2 <= 1'b0; r_off_q2 <= '0;
        end else begin
            r_ok_q1  <= r_ok;
            r_par_q1 <= r_k[0];
            r_off_q1 <= r_off;
            r_ae_q1  <= AW'(r_k_inc >> 1);
            r_ao_q1  <= AW'(r_k >> 1);
            r_ok_q2  <= r_ok_q1;
            r_par_q2 <= r_par_q1;
            r_off_q2 <= r_off_q1;
        end
    end

    // ---------------- banks ----------------
    word_t rd_e, rd_o;
    pix_bank #(.DEPTH(BANK_D), .AW(AW)) u_even (
        .clk(clk), .rst_n(rst_n), .be(w_be_e_q), .waddr(w_ae_q),
        .wdata(w_d_e_q), .raddr(r_ae_q1), .rdata(rd_e)
    );
    pix_bank #(.DEPTH(BANK_D), .AW(AW)) u_odd (
        .clk(clk), .rst_n(rst_n), .be(w_be_o_q), .waddr(w_ao_q),
        .wdata(w_d_o_q), .raddr(r_ao_q1), .rdata(rd_o)
    );

    // Rebuild the word pair in stream order and pick the pixel.
    pair_t r_pair;
    always_comb begin
        r_pair = r_par_q2 ? {rd_e, rd_o} : {rd_o, rd_e};
        rd_pix = r_ok_q2 ? r_pair[r_off_q2 +: 2] : 2'b00;
    end

    // ---------------- assertions ----------------
    logic [1:0] age;
    // Count cycles since reset, saturating, to qualify history checks.
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd3) age <= age + 1'b1;
    end

    assert_wr_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({w_be_o_q, w_be_e_q}) == (w_ok_q ? 2 : 0))
        else $error("write enable count wrong");

    assert_oob_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((age >= 2'd2) && !$past(r_ok, 2)) |-> (rd_pix == 2'b00))
        else $error("out-of-range read not zero");
endmodule

// File: tb/packed_pix_fb_test.sv
`timescale 1ns/1ps
module packed_pix_fb_test;
    localparam int XW = 7;
    localparam int YW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [XW-1:0] wr_x = '0;
    logic [YW-1:0] wr_y = '0;
    logic [1:0]    wr_pix = '0;
    logic [XW-1:0] rd_x = '0;
    logic [YW-1:0] rd_y = '0;
    logic [1:0]    rd_pix;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    packed_pix_fb uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y),
        .wr_pix(wr_pix), .rd_x(rd_x), .rd_y(rd_y), .rd_pix(rd_pix)
    );

    // Full-width divider for the exhaustive sweep.
    logic [17:0] div_b = '0;
    logic [17:0] div_q;
    logic [3:0]  div_r;
    pix_div9 #(.BW(18)) chk_div (.b(div_b), .q(div_q), .r(div_r));

    typedef struct packed {
        logic       wr;
        logic [6:0] x;
        logic [5:0] y;
        logic [1:0] pix;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t TAB [NV] = '{
        '{1'b1, 7'd3,  6'd0,  2'b01, 4'd4},  // R4 left neighbour
        '{1'b1, 7'd4,  6'd0,  2'b10, 4'd4},  // R4 straddling pixel, offset 8
        '{1'b1, 7'd5,  6'd0,  2'b11, 4'd4},  // R4 right neighbour
        '{1'b0, 7'd3,  6'd0,  2'b01, 4'd4},
        '{1'b0, 7'd4,  6'd0,  2'b10, 4'd2},  // R2 straddle readback
        '{1'b0, 7'd5,  6'd0,  2'b11, 4'd4},
        '{1'b1, 7'd4,  6'd0,  2'b01, 4'd4},  // R4 overwrite straddle
        '{1'b0, 7'd3,  6'd0,  2'b01, 4'd4},
        '{1'b0, 7'd4,  6'd0,  2'b01, 4'd4},
        '{1'b0, 7'd5,  6'd0,  2'b11, 4'd4},
        '{1'b1, 7'd0,  6'd0,  2'b11, 4'd8},  // R8 codes
        '{1'b1, 7'd1,  6'd0,  2'b10, 4'd8},
        '{1'b1, 7'd2,  6'd0,  2'b00, 4'd8},
        '{1'b0, 7'd0,  6'd0,  2'b11, 4'd8},
        '{1'b0, 7'd1,  6'd0,  2'b10, 4'd8},
        '{1'b0, 7'd2,  6'd0,  2'b00, 4'd8},
        '{1'b1, 7'd63, 6'd31, 2'b10, 4'd2},  // R2 last pixel
        '{1'b0, 7'd63, 6'd31, 2'b10, 4'd2},
        '{1'b1, 7'd7,  6'd0,  2'b01, 4'd2},  // R2 odd word 1, offset 5
        '{1'b1, 7'd8,  6'd0,  2'b10, 4'd2},  // R2 odd word 1, offset 7
        '{1'b0, 7'd7,  6'd0,  2'b01, 4'd2},
        '{1'b0, 7'd8,  6'd0,  2'b10, 4'd2},
        '{1'b1, 7'd0,  6'd1,  2'b11, 4'd7},  // R7 alias target
        '{1'b1, 7'd64, 6'd0,  2'b01, 4'd7},  // R7 x out of range
        '{1'b0, 7'd0,  6'd1,  2'b11, 4'd7},
        '{1'b0, 7'd64, 6'd0,  2'b00, 4'd7},
        '{1'b0, 7'd5,  6'd32, 2'b00, 4'd7}   // R7 y out of range
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [6:0] x, input logic [5:0] y, input logic [1:0] p);
        @(negedge clk);
        wr_en = 1'b1; wr_x = x; wr_y = y; wr_pix = p;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [6:0] x, input logic [5:0] y, input logic [1:0] e, input string req);
        @(negedge clk);
        rd_x = x; rd_y = y;
        @(negedge clk);
        @(negedge clk);
        check(32'(rd_pix), 32'(e), req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: output quiet under reset
        repeat (3) @(negedge clk);
        check(32'(rd_pix), 32'd0, "R1");
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (TAB[i].wr) do_write(TAB[i].x, TAB[i].y, TAB[i].pix);
            else do_read(TAB[i].x, TAB[i].y, TAB[i].pix, $sformatf("R%0d", TAB[i].req));
        end

        // R5: same-cycle write and read, straddling pixel 13 and odd-word pixel 7
        do_write(7'd13, 6'd0, 2'b01);
        @(negedge clk);
        wr_en = 1'b1; wr_x = 7'd13; wr_y = 6'd0; wr_pix = 2'b10;
        rd_x = 7'd13; rd_y = 6'd0;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);
        check(32'(rd_pix), 32'd2, "R5");
        @(negedge clk);
        wr_en = 1'b1; wr_x = 7'd7; wr_y = 6'd0; wr_pix = 2'b11;
        rd_x = 7'd7; rd_y = 6'd0;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);
        check(32'(rd_pix), 32'd3, "R5");
        do_read(7'd8, 6'd0, 2'b10, "R4");

        // R6: streamed reads, offsets 6, 8, 1 after a held read of (0,1)
        @(negedge clk); rd_x = 7'd0; rd_y = 6'd1;
        repeat (3) @(negedge clk);
        rd_x = 7'd3; rd_y = 6'd0;            // neg0
        @(negedge clk);
        check(32'(rd_pix), 32'd3, "R6");     // still previous read
        rd_x = 7'd4;                          // neg1
        @(negedge clk);
        check(32'(rd_pix), 32'd1, "R6");     // pixel 3
        rd_x = 7'd5;                          // neg2
        @(negedge clk);
        check(32'(rd_pix), 32'd1, "R6");     // pixel 4
        @(negedge clk);
        check(32'(rd_pix), 32'd3, "R6");     // pixel 5

        // R3: exhaustive divider sweep at full width
        begin
            int bad = 0;
            for (int n = 0; n < 131072; n++) begin
                div_b = 18'(2 * n);
                #1;
                if (div_q !== 18'((2 * n) / 9) || div_r !== 4'((2 * n) % 9)) begin
                    if (bad == 0)
                        $display("FAIL R3 n=%0d actual=%0d/%0d expected=%0d/%0d",
                                 n, div_q, div_r, (2 * n) / 9, (2 * n) % 9);
                    bad++;
                end
            end
            checks++;
            if (bad != 0) errors++;
        end

        finish_run();
    end
endmodule